// File: doc/BRIEF.md
# Dual-Channel Third-Order Sinc Decimator

This block turns two multi-bit delta-sigma modulator streams, one from a current channel and one from a voltage channel, into signed 16-bit conversion words. Each channel runs a cascade of three integrators at the modulator sample rate and three single-delay differentiators at the output rate. Together they give the cube of a 64-tap moving-sum response. A new modulator code is taken every `SAMPLE_DIV` master clocks, and one word is produced for every `OSR` codes.

Both channels run from one shared set of clock enables, so their results are produced on the same master clock edge and leave the block under a single valid strobe. The scaled result is clamped to the signed 16-bit range instead of wrapping. While reset is asserted both words read zero. After reset is released, the strobe stays low for the first three output periods while the differentiator delays fill.

Top module: `sinc3_dual`

## Requirements
- R1: With a constant two's-complement code c on a channel, the settled output word equals c·8192 (DC gain OSR³ = 2^18, shifted right by 5), as long as that value lies within the signed 16-bit range.
- R2: The valid strobe pulses once every 256 master clocks (4 clocks per modulator code × 64 codes per word).
- R3: While rst_ni is low, both output words read 0x0000 and the strobe is low, whatever the input codes are.
- R4: After reset is released, the first three output periods carry no strobe. The first strobe is set on the 1024th rising clock edge after release.
- R5: A scaled result above 32767 is clamped to 0x7FFF.
- R6: A scaled result below −32768 is clamped to 0x8000.
- R7: The two channels are filtered independently and in lock-step. Both words belong to the same strobe even when one channel clamps high and the other clamps low.
- R8: The strobe lasts one clock. Both output words change only on a strobe clock and hold their value between strobes.
- R9: The input code is 4-bit two's complement over the full range −8..7. Code −4 maps to exactly 0x8000 without clamping.
- R10: A reset asserted in the middle of a run clears both words at once and restarts the three-period fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cur_code_i | input | 4 | Current-channel modulator code, two's complement |
| volt_code_i | input | 4 | Voltage-channel modulator code, two's complement |
| cur_word_o | output | 16 | Current-channel conversion result, signed |
| volt_word_o | output | 16 | Voltage-channel conversion result, signed |
| word_vld_o | output | 1 | One-clock strobe marking fresh results on both words |

## Verification
Clamping can hit both channels in the same output cycle, with opposite signs. The stimulus table includes rows where the current channel overflows upward while the voltage channel overflows downward. Each of those rows is judged on one strobe: 0x7FFF and 0x8000 must arrive together, neither channel's wrap may leak into the other, and the strobe must stay on its 256-clock grid. A second collision is a reset that lands mid-period. The bench asserts it between strobes and checks that both words clear at once and that the fill count restarts from zero.

// File: rtl/sinc3_dual_pkg.sv
package sinc3_dual_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_CUR = 0;
  localparam int unsigned CH_VOLT = 1;

  function automatic int unsigned acc_width(int unsigned in_w, int unsigned order, int unsigned osr);
    return in_w + order * $clog2(osr);
  endfunction
endpackage

// File: rtl/sinc3_enables.sv
module sinc3_enables #(
  parameter int unsigned SAMPLE_DIV = 4,
  parameter int unsigned OSR        = 64,
  parameter int unsigned FILL       = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic smp_en_o,
  output logic dec_en_o,
  output logic fill_done_o
);
  localparam int unsigned DIV_W  = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam int unsigned DEC_W  = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int unsigned FILL_W = $clog2(FILL + 1);

  logic [DIV_W-1:0]  div_q;
  logic [DEC_W-1:0]  dec_q;
  logic [FILL_W-1:0] fill_q;

  assign smp_en_o    = (div_q == DIV_W'(SAMPLE_DIV - 1));
  assign dec_en_o    = smp_en_o && (dec_q == DEC_W'(OSR - 1));
  assign fill_done_o = (fill_q == FILL_W'(FILL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else if (smp_en_o) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q <= '0;
    end else if (dec_en_o) begin
      dec_q <= '0;
    end else if (smp_en_o) begin
      dec_q <= dec_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
    end else if (dec_en_o && !fill_done_o) begin
      fill_q <= fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
  parameter int unsigned IN_W  = 4,
  parameter int unsigned ACC_W = 22,
  parameter int unsigned ORDER = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [IN_W-1:0]  code_i,
  output logic signed [ACC_W-1:0] acc_o
);
  logic signed [ACC_W-1:0] acc_q [ORDER];
  logic signed [ACC_W-1:0] feed  [ORDER];

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign feed[k] = {{(ACC_W-IN_W){code_i[IN_W-1]}}, code_i};
    end else begin : g_tail
      assign feed[k] = acc_q[k-1];
    end
    // modular sum: wrap cancels in the differentiators
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q[k] <= '0;
      end else if (en_i) begin
        acc_q[k] <= acc_q[k] + feed[k];
      end
    end
  end

  assign acc_o = acc_q[ORDER-1];
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
  parameter int unsigned ACC_W = 22,
  parameter int unsigned ORDER = 3,
  parameter int unsigned OUT_W = 16,
  parameter int unsigned SHIFT = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [ACC_W-1:0] acc_i,
  output logic signed [OUT_W-1:0] res_o
);
  localparam int unsigned SH_W = ACC_W - SHIFT;

  logic signed [ACC_W-1:0] stg   [ORDER+1];
  logic signed [ACC_W-1:0] dly_q [ORDER];
  logic signed [SH_W-1:0]  shd;
  logic                    fits;

  assign stg[0] = acc_i;

  for (genvar k = 0; k < ORDER; k++) begin : g_diff
    assign stg[k+1] = stg[k] - dly_q[k];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dly_q[k] <= '0;
      end else if (en_i) begin
        dly_q[k] <= stg[k];
      end
    end
  end

  assign shd = $signed(stg[ORDER][ACC_W-1:SHIFT]);
  // in range when all bits above the output sign match it
  assign fits = (&shd[SH_W-1:OUT_W-1]) || !(|shd[SH_W-1:OUT_W-1]);

  always_comb begin
    if (fits) begin
      res_o = shd[OUT_W-1:0];
    end else if (shd[SH_W-1]) begin
      res_o = {1'b1, {(OUT_W-1){1'b0}}};
    end else begin
      res_o = {1'b0, {(OUT_W-1){1'b1}}};
    end
  end
endmodule

// File: rtl/sinc3_dual.sv
module sinc3_dual
  import sinc3_dual_pkg::*;
#(
  parameter int unsigned IN_W       = 4,
  parameter int unsigned OUT_W      = 16,
  parameter int unsigned OSR        = 64,
  parameter int unsigned ORDER      = 3,
  parameter int unsigned SAMPLE_DIV = 4,
  parameter int unsigned SHIFT      = 5,
  parameter int unsigned FILL       = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IN_W-1:0]  cur_code_i,
  input  logic [IN_W-1:0]  volt_code_i,
  output logic [OUT_W-1:0] cur_word_o,
  output logic [OUT_W-1:0] volt_word_o,
  output logic             word_vld_o
);
  localparam int unsigned ACC_W = acc_width(IN_W, ORDER, OSR);

  logic smp_en, dec_en, fill_done, publish;
  logic signed [IN_W-1:0]  code  [NUM_CH];
  logic signed [ACC_W-1:0] integ [NUM_CH];
  logic signed [OUT_W-1:0] res   [NUM_CH];
  logic [OUT_W-1:0]        word_q[NUM_CH];
  logic                    vld_q;

  assign code[CH_CUR]  = cur_code_i;
  assign code[CH_VOLT] = volt_code_i;
  assign publish       = dec_en && fill_done;

  sinc3_enables #(
    .SAMPLE_DIV(SAMPLE_DIV),
    .OSR       (OSR),
    .FILL      (FILL)
  ) u_en (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .smp_en_o   (smp_en),
    .dec_en_o   (dec_en),
    .fill_done_o(fill_done)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    sinc3_integ #(
      .IN_W (IN_W),
      .ACC_W(ACC_W),
      .ORDER(ORDER)
    ) u_integ (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (smp_en),
      .code_i(code[c]),
      .acc_o (integ[c])
    );

    sinc3_comb #(
      .ACC_W(ACC_W),
      .ORDER(ORDER),
      .OUT_W(OUT_W),
      .SHIFT(SHIFT)
    ) u_comb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (dec_en),
      .acc_i (integ[c]),
      .res_o (res[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q[c] <= '0;
      end else if (publish) begin
        word_q[c] <= res[c];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= publish;
    end
  end

  assign cur_word_o  = word_q[CH_CUR];
  assign volt_word_o = word_q[CH_VOLT];
  assign word_vld_o  = vld_q;
endmodule

// File: rtl/sinc3_dual_chk.sv
module sinc3_dual_chk #(
  parameter int unsigned OUT_W      = 16,
  parameter int unsigned OSR        = 64,
  parameter int unsigned SAMPLE_DIV = 4,
  parameter int unsigned FILL       = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [OUT_W-1:0] cur_word_o,
  input logic [OUT_W-1:0] volt_word_o,
  input logic             word_vld_o
);
  localparam int PERIOD = int'(OSR * SAMPLE_DIV);
  localparam int FIRST  = int'((FILL + 1) * OSR * SAMPLE_DIV);

  int   since_rst;
  int   gap;
  logic seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_rst <= 0;
      gap       <= 0;
      seen      <= 1'b0;
    end else begin
      if (since_rst < 1000000) since_rst <= since_rst + 1;
      if (word_vld_o) begin
        gap  <= 1;
        seen <= 1'b1;
      end else if (gap < 1000000) begin
        gap <= gap + 1;
      end
    end
  end

  p_reset_zero_r3: assert property (@(posedge clk_i)
    !rst_ni |-> (cur_word_o == '0 && volt_word_o == '0 && !word_vld_o));

  p_first_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_o && !seen) |-> since_rst == FIRST);

  p_period_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_o && seen) |-> gap == PERIOD);

  p_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |=> !word_vld_o);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_vld_o |-> ($stable(cur_word_o) && $stable(volt_word_o)));
endmodule

bind sinc3_dual sinc3_dual_chk #(
  .OUT_W     (OUT_W),
  .OSR       (OSR),
  .SAMPLE_DIV(SAMPLE_DIV),
  .FILL      (FILL)
) chk_i (.*);

// File: tb/sinc3_dual_tb_top.sv
module sinc3_dual_tb_top;
  localparam int N_ROWS = 7;
  // stimulus codes and expected settled words per channel
  localparam int T_CUR [N_ROWS] = '{0, 1, 3, -4, 4, 7, -1};
  localparam int T_VOLT[N_ROWS] = '{0, -1, -3, 2, -5, -8, 3};
  localparam int E_CUR [N_ROWS] = '{0, 8192, 24576, -32768, 32767, 32767, -8192};
  localparam int E_VOLT[N_ROWS] = '{0, -8192, -24576, 16384, -32768, -32768, 24576};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  cur_code_i = '0;
  logic [3:0]  volt_code_i = '0;
  logic [15:0] cur_word_o;
  logic [15:0] volt_word_o;
  logic        word_vld_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk_i = ~clk_i;

  sinc3_dual dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cur_code_i (cur_code_i),
    .volt_code_i(volt_code_i),
    .cur_word_o (cur_word_o),
    .volt_word_o(volt_word_o),
    .word_vld_o (word_vld_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic string row_tag(input int code, input int exp);
    if (code * 8192 > 32767) return "R5";
    if (code * 8192 < -32768) return "R6";
    if (exp == -32768) return "R9";
    return "R1";
  endfunction

  task automatic wait_valid();
    do @(negedge clk_i); while (!word_vld_o);
  endtask

  task automatic edges_to_valid(output int n);
    n = 0;
    do begin
      @(posedge clk_i);
      n++;
      @(negedge clk_i);
    end while (!word_vld_o);
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int hold_c, hold_v;
    logic moved;

    // R3: zero in reset with non-zero codes applied
    cur_code_i  = 4'sd7;
    volt_code_i = -4'sd8;
    repeat (6) @(negedge clk_i);
    chk("R3 cur", int'($signed(cur_word_o)), 0);
    chk("R3 volt", int'($signed(volt_word_o)), 0);
    chk("R3 vld", int'(word_vld_o), 0);

    cur_code_i  = '0;
    volt_code_i = '0;
    rst_ni      = 1'b1;
    edges_to_valid(n);
    chk("R4 first strobe edge", n, 1024);

    edges_to_valid(n);
    chk("R2 strobe period", n, 256);

    // R8: one-clock strobe, then hold while inputs move
    cur_code_i  = 4'sd3;
    volt_code_i = -4'sd5;
    hold_c = int'($signed(cur_word_o));
    hold_v = int'($signed(volt_word_o));
    @(negedge clk_i);
    chk("R8 strobe width", int'(word_vld_o), 0);
    moved = 1'b0;
    repeat (150) begin
      @(negedge clk_i);
      if (int'($signed(cur_word_o)) != hold_c || int'($signed(volt_word_o)) != hold_v)
        moved = 1'b1;
    end
    chk("R8 hold between strobes", int'(moved), 0);

    for (int i = 0; i < N_ROWS; i++) begin
      cur_code_i  = 4'(T_CUR[i]);
      volt_code_i = 4'(T_VOLT[i]);
      repeat (5) wait_valid();
      chk({row_tag(T_CUR[i], E_CUR[i]), " cur"}, int'($signed(cur_word_o)), E_CUR[i]);
      chk({row_tag(T_VOLT[i], E_VOLT[i]), " volt"}, int'($signed(volt_word_o)), E_VOLT[i]);
      // R7: opposite clamps on the same strobe
      if (i == 4) chk("R7 split clamp", int'($signed(cur_word_o)) - int'($signed(volt_word_o)), 65535);
    end

    // R10: reset between strobes
    cur_code_i  = 4'sd2;
    volt_code_i = 4'sd1;
    repeat (5) wait_valid();
    repeat (100) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R10 cur cleared", int'($signed(cur_word_o)), 0);
    chk("R10 volt cleared", int'($signed(volt_word_o)), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    edges_to_valid(n);
    chk("R10 fill restart", n, 1024);
    repeat (4) wait_valid();
    chk("R1 cur after restart", int'($signed(cur_word_o)), 16384);
    chk("R1 volt after restart", int'($signed(volt_word_o)), 8192);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule